// File: doc/BRIEF.md
# Pulse Period Sweep Unit

This block owns the 11-bit tone period of one square-wave voice and can step it up or down at a programmable rate. Software loads a one-byte setup word that holds an enable, a divider period, a direction and a shift count. A direct write port sets the period outright. An external half-frame strobe clocks the internal divider, and each time the divider expires the period moves by a right-shifted copy of itself.

The block computes the candidate next period (the target) combinationally at all times. It raises a mute output whenever the current period is too short or an upward target would overflow 11 bits. This happens whatever the enable and divider state are. The `CHANNEL` parameter picks how downward steps are formed. Value 0 adds the one's complement of the shifted value, so the result is one lower than a true difference. Value 1 subtracts exactly.

The divider is a two-state machine. `ST_ARMED` means a reload is pending, because a setup write arrived since the last strobe. `ST_RUN` means the divider counts normally. The transitions are:
- **arm**: any state goes to `ST_ARMED` on a setup write.
- **consume**: `ST_ARMED` goes to `ST_RUN` on a strobe.
- **count**, **expire** and **hold**: these keep the machine in `ST_RUN` on a strobe. **count** applies when the counter is non-zero. **expire** applies when the counter is zero and the sweep is enabled. **hold** applies when the counter is zero and the sweep is disabled.

Top module: `pulse_sweep`

## Requirements
- R1: The setup byte is laid out with bit 7 as enable, bits 6..4 as the divider value P, bit 3 as negate (1 = downward) and bits 2..0 as the shift count. Every setup write arms the reload, whatever value is written.
- R2: On a strobe while armed, the counter loads P and the machine disarms. The period is adjusted on that strobe only if the counter was zero beforehand and enable is 1.
- R3: On a strobe while not armed, a non-zero counter decrements by one. A zero counter with enable at 1 reloads P and adjusts the period. A zero counter with enable at 0 stays at zero. The net effect is one adjustment every P+1 strobes.
- R4: In add mode, the target equals period + (period >> shift).
- R5: mute is 1 exactly when period < 8, or when negate is 0 and period + (period >> shift) > 0x7FF. This holds whatever the enable, divider and shift-update state are.
- R6: The period changes through the sweep only on a divider firing with enable 1, a non-zero shift and mute 0. A shift count of zero never changes the period.
- R7: In negate mode with CHANNEL=0, the adjustment gives period − (period >> shift) − 1. With CHANNEL=1 it gives period − (period >> shift).
- R8: In negate mode, mute depends only on the period being below 8; a downward target never signals overflow.
- R9: A direct period write replaces the period on the next edge, even when a sweep adjustment falls in the same cycle. Mute and target then follow the new value.
- R10: A synchronous active-high reset clears the period, the counter, the armed flag and all setup fields. After reset, period_out is 0 and mute is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_we | input | 1 | Setup byte write strobe |
| setup_data | input | 8 | Setup byte |
| period_we | input | 1 | Direct period write strobe |
| period_data | input | 11 | Period value to write |
| half_frame | input | 1 | Divider clock strobe, one cycle wide |
| period_out | output | 11 | Current tone period |
| mute | output | 1 | Silence request to the mixer |

## Verification
The bench builds two copies side by side, one with CHANNEL=0 and one with CHANNEL=1, and drives them with identical stimulus. Any difference between them therefore exposes the two downward-step rules directly. Each copy has the default 11-bit period, so all 2048 periods can be swept under every shift count and both directions, which checks mute and overflow exhaustively. Every divider value from 0 to 7 is also run across many strobes, along with re-arming while the counter is mid-count.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    // Divider control: armed means a reload is pending from a setup write.
    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ARMED = 1'b1
    } div_state_e;

endpackage

// File: rtl/sweep_divider.sv
module sweep_divider
    import sweep_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload_req,
    input  logic             tick,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_period,
    output logic             fire
);

    div_state_e       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick) begin
            unique case (state_q)
                ST_ARMED: begin            // consume
                    cnt_d   = div_period;
                    state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (!cnt_zero)   cnt_d = cnt_q - 1'b1;  // count
                    else if (enable) cnt_d = div_period;    // expire
                end                                         // else hold
                default: state_d = ST_RUN;
            endcase
        end
        if (reload_req) state_d = ST_ARMED;                 // arm
    end

    // Output: divider clock
    always_comb begin
        fire = tick && enable && cnt_zero;
    end

    p_reload_arms_r1: assert property (@(posedge clk) disable iff (rst)
        reload_req |=> state_q == ST_ARMED);

    p_armed_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && tick && !reload_req) |=> state_q == ST_RUN);

    p_armed_loads_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && tick) |=> cnt_q == $past(div_period));

    p_count_dec_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && tick && !cnt_zero) |=> cnt_q == DIV_W'($past(cnt_q) - 1'b1));

    p_hold_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && tick && cnt_zero && !enable) |=> cnt_q == '0);

endmodule

// File: rtl/sweep_target.sv
module sweep_target #(
    parameter int PER_W      = 11,
    parameter int SHIFT_W    = 3,
    parameter int MIN_PERIOD = 8,
    parameter int CHANNEL    = 0
) (
    input  logic [PER_W-1:0]   period,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               negate,
    output logic [PER_W-1:0]   target,
    output logic               mute
);

    localparam int EXT_W = PER_W + 1;

    logic [PER_W-1:0] shifted;
    logic [EXT_W-1:0] sum;
    logic [EXT_W-1:0] diff;
    logic             borrow;
    logic             overflow;
    logic             too_low;

    assign shifted = period >> shift;
    assign sum     = {1'b0, period} + {1'b0, shifted};

    generate
        if (CHANNEL == 0) begin : g_ones
            assign diff = {1'b0, period} + {1'b0, ~shifted};
            // carry out set means no borrow in ones-complement form
            assign borrow = ~diff[PER_W];
        end else begin : g_twos
            assign diff   = {1'b0, period} - {1'b0, shifted};
            assign borrow = diff[PER_W];
        end
    endgenerate

    assign overflow = !negate && sum[PER_W];
    assign too_low  = (period < PER_W'(MIN_PERIOD));

    always_comb begin
        if (negate) target = borrow ? '0 : diff[PER_W-1:0];
        else        target = sum[PER_W-1:0];
        mute = too_low || overflow;
    end

    always_comb begin
        if (too_low) p_low_mutes_r5: assert (mute);
        if (negate && !too_low) p_no_overflow_r8: assert (!mute);
    end

endmodule

// File: rtl/pulse_sweep.sv
module pulse_sweep #(
    parameter int PER_W      = 11,
    parameter int DIV_W      = 3,
    parameter int SHIFT_W    = 3,
    parameter int MIN_PERIOD = 8,
    parameter int CHANNEL    = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               setup_we,
    input  logic [7:0]         setup_data,
    input  logic               period_we,
    input  logic [PER_W-1:0]   period_data,
    input  logic               half_frame,
    output logic [PER_W-1:0]   period_out,
    output logic               mute
);

    localparam int SETUP_W = 1 + DIV_W + 1 + SHIFT_W;
    localparam int NEG_BIT = SHIFT_W;
    localparam int DIV_LSB = SHIFT_W + 1;
    localparam int EN_BIT  = SETUP_W - 1;

    typedef struct packed {
        logic               en;
        logic [DIV_W-1:0]   div;
        logic               neg;
        logic [SHIFT_W-1:0] sh;
    } setup_t;

    setup_t             cfg_q;
    logic [PER_W-1:0]   period_q;
    logic [PER_W-1:0]   target;
    logic               fire;
    logic               sweep_upd;

    // Setup register
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (setup_we) begin
            cfg_q.en  <= setup_data[EN_BIT];
            cfg_q.div <= setup_data[DIV_LSB +: DIV_W];
            cfg_q.neg <= setup_data[NEG_BIT];
            cfg_q.sh  <= setup_data[SHIFT_W-1:0];
        end
    end

    sweep_divider #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .reload_req (setup_we),
        .tick       (half_frame),
        .enable     (cfg_q.en),
        .div_period (cfg_q.div),
        .fire       (fire)
    );

    sweep_target #(
        .PER_W      (PER_W),
        .SHIFT_W    (SHIFT_W),
        .MIN_PERIOD (MIN_PERIOD),
        .CHANNEL    (CHANNEL)
    ) u_tgt (
        .period (period_q),
        .shift  (cfg_q.sh),
        .negate (cfg_q.neg),
        .target (target),
        .mute   (mute)
    );

    assign sweep_upd = fire && cfg_q.en && (cfg_q.sh != '0) && !mute;

    // Period register: direct write wins over sweep update
    always_ff @(posedge clk) begin
        if (rst)            period_q <= '0;
        else if (period_we) period_q <= period_data;
        else if (sweep_upd) period_q <= target;
    end

    assign period_out = period_q;

    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        period_we |=> period_out == $past(period_data));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!period_we && !half_frame) |=> $stable(period_out));

    p_muted_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!period_we && mute) |=> $stable(period_out));

    p_shift0_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!period_we && cfg_q.sh == '0) |=> $stable(period_out));

    p_disabled_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!period_we && !cfg_q.en) |=> $stable(period_out));

endmodule

// File: tb/pulse_sweep_tb.sv
module pulse_sweep_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst;
    logic        setup_we;
    logic [7:0]  setup_data;
    logic        period_we;
    logic [10:0] period_data;
    logic        half_frame;
    logic [10:0] per0, per1;
    logic        mute0, mute1;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model
    int m_cnt, m_flag, m_en, m_p, m_neg, m_sh, m_per0, m_per1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_sweep #(.CHANNEL(0)) u_dut (
        .clk(clk), .rst(rst), .setup_we(setup_we), .setup_data(setup_data),
        .period_we(period_we), .period_data(period_data), .half_frame(half_frame),
        .period_out(per0), .mute(mute0)
    );

    pulse_sweep #(.CHANNEL(1)) u_dut_ch2 (
        .clk(clk), .rst(rst), .setup_we(setup_we), .setup_data(setup_data),
        .period_we(period_we), .period_data(period_data), .half_frame(half_frame),
        .period_out(per1), .mute(mute1)
    );

    function automatic int exp_mute(int per, int sh, int neg);
        if (per < 8) return 1;
        if (neg == 0 && per + (per >> sh) > 2047) return 1;
        return 0;
    endfunction

    function automatic int exp_target(int per, int sh, int neg, int ch);
        int s = per >> sh;
        if (neg == 0) return per + s;
        if (ch == 0)  return (per - s - 1 < 0) ? 0 : per - s - 1;
        return per - s;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_both(string req);
        chk(req, int'(per0), m_per0);
        chk(req, int'(per1), m_per1);
        chk(req, int'(mute0), exp_mute(m_per0, m_sh, m_neg));
        chk(req, int'(mute1), exp_mute(m_per1, m_sh, m_neg));
    endtask

    task automatic model_strobe();
        int fire = 0;
        if (m_flag != 0) begin
            fire   = (m_cnt == 0 && m_en != 0) ? 1 : 0;
            m_cnt  = m_p;
            m_flag = 0;
        end else if (m_cnt != 0) begin
            m_cnt--;
        end else if (m_en != 0) begin
            m_cnt = m_p;
            fire  = 1;
        end
        if (fire != 0 && m_sh != 0) begin
            if (exp_mute(m_per0, m_sh, m_neg) == 0) m_per0 = exp_target(m_per0, m_sh, m_neg, 0);
            if (exp_mute(m_per1, m_sh, m_neg) == 0) m_per1 = exp_target(m_per1, m_sh, m_neg, 1);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_flag = 0; m_en = 0; m_p = 0; m_neg = 0; m_sh = 0;
        m_per0 = 0; m_per1 = 0;
    endtask

    // R1: enable bit 7, P bits 6..4, negate bit 3, shift bits 2..0
    task automatic setup_write(int en, int p, int neg, int sh);
        @(negedge clk);
        setup_we   = 1'b1;
        setup_data = 8'((en << 7) | (p << 4) | (neg << 3) | sh);
        @(negedge clk);
        setup_we = 1'b0;
        m_en = en; m_p = p; m_neg = neg; m_sh = sh; m_flag = 1;
    endtask

    task automatic period_write(int v);
        @(negedge clk);
        period_we   = 1'b1;
        period_data = 11'(v);
        @(negedge clk);
        period_we = 1'b0;
        m_per0 = v; m_per1 = v;
    endtask

    task automatic strobe();
        @(negedge clk);
        half_frame = 1'b1;
        @(negedge clk);
        half_frame = 1'b0;
        model_strobe();
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; setup_we = 0; setup_data = 0; period_we = 0;
        period_data = 0; half_frame = 0;
        do_reset();

        // R10: reset state
        chk("R10 period after reset", int'(per0), 0);
        chk("R10 mute after reset", int'(mute0), 1);
        chk("R10 ch2 period after reset", int'(per1), 0);

        // R10: setup cleared, strobes do nothing
        period_write(256);
        for (int i = 0; i < 4; i++) begin
            strobe();
            chk("R10 setup cleared", int'(per0), 256);
        end

        // R5 R8 R9: exhaustive mute sweep, sweep disabled
        for (int neg = 0; neg < 2; neg++) begin
            for (int sh = 0; sh < 8; sh++) begin
                setup_write(0, 0, neg, sh);
                for (int per = 0; per < 2048; per++) begin
                    period_write(per);
                    check_both(neg != 0 ? "R8 R9 negate mute" : "R5 R9 add mute");
                end
            end
        end

        // R4 R7 R6: every shift, both directions, P=0 fires every strobe
        for (int neg = 0; neg < 2; neg++) begin
            for (int sh = 0; sh < 8; sh++) begin
                for (int st = 0; st < 4; st++) begin
                    int start = (st == 0) ? 5 : (st == 1) ? 100 : (st == 2) ? 1000 : 1900;
                    setup_write(1, 0, neg, sh);
                    period_write(start);
                    for (int k = 0; k < 5; k++) begin
                        strobe();
                        check_both(neg != 0 ? "R7 negate step" : "R4 R6 add step");
                    end
                end
            end
        end

        // R7 explicit: 0x100 >> 1 downward
        setup_write(1, 0, 1, 1);
        period_write(256);
        strobe();
        chk("R7 ones-complement step", int'(per0), 127);
        chk("R7 twos-complement step", int'(per1), 128);

        // R2 R3: every divider value over many strobes
        for (int p = 0; p < 8; p++) begin
            setup_write(1, p, 0, 4);
            period_write(64);
            for (int k = 0; k < 20; k++) begin
                strobe();
                check_both("R3 divider rate");
            end
            // R2: re-arm mid-count
            setup_write(1, (p + 3) % 8, 1, 3);
            for (int k = 0; k < 12; k++) begin
                strobe();
                check_both("R2 rearm reload");
            end
        end

        // R3: disabled with counter at zero holds
        setup_write(0, 2, 0, 1);
        period_write(300);
        for (int k = 0; k < 6; k++) begin
            strobe();
            check_both("R3 disabled hold");
        end

        // R6: shift zero never changes, add-mode overflow still mutes
        setup_write(1, 0, 0, 0);
        period_write(1500);
        for (int k = 0; k < 3; k++) begin
            strobe();
            chk("R6 shift zero hold", int'(per0), 1500);
            chk("R6 shift zero overflow mute", int'(mute0), 1);
        end

        // R6: muted low period not swept
        setup_write(1, 0, 0, 1);
        period_write(5);
        strobe();
        chk("R6 muted no update", int'(per0), 5);

        // R9: direct write beats same-cycle sweep
        setup_write(1, 0, 0, 1);
        period_write(200);
        @(negedge clk);
        half_frame  = 1'b1;
        period_we   = 1'b1;
        period_data = 11'd77;
        @(negedge clk);
        half_frame = 1'b0;
        period_we  = 1'b0;
        model_strobe();
        m_per0 = 77; m_per1 = 77;
        chk("R9 write priority ch1", int'(per0), 77);
        chk("R9 write priority ch2", int'(per1), 77);
        strobe();
        check_both("R9 target from new value");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule